// File: doc/BRIEF.md
# Command Packet Front End for a Display Serial Link

This block sits between a processor's register bus and the packet engine of a display serial link. Software uses it to queue generic and display-command packets and to collect the data returned by read requests. Payload words go into a write-payload FIFO first. Writing the 32-bit header word then commits the whole packet for transmission: the header goes into a command FIFO together with two per-packet option bits.

The link side of the block works in packet order. It presents each queued header, then the payload words that the header's byte count calls for, on a valid/ready word interface. Returned read data arrives on a separate word input and lands in a read-payload FIFO, which software drains through the same payload register.

A status register reports whether each FIFO is empty or full and whether a read request is still waiting for its response. Two sticky bits record dropped writes and reads of an empty FIFO. ECC and CRC generation, lane serialization and the physical layer belong to the engine downstream. The bench models that engine.

Register map (word index on `wr_addr`/`rd_addr`):
- 0 = option register: bit0 low-power select, bit1 acknowledge-request enable.
- 1 = header (write only).
- 2 = payload: a write pushes to the write-payload FIFO, a read pops the read-payload FIFO.
- 3 = status.

Header fields:
- bits 5:0: data type.
- bits 7:6: virtual channel.
- bits 23:8: byte count, or two parameters for a short packet.

Top module: `dsi_cmd_pkt_if`

## Requirements
- R1: After reset the status register (index 3) reads 0x15: bit0 command FIFO empty, bit2 write-payload empty and bit4 read-payload empty are set. All other bits, including sticky bits 8 and 9, are clear, and the option register reads 0.
- R2: Status bit1 (command full) and bit3 (write-payload full) are set exactly when the FIFO holds its depth in entries. Bit0 and bit2 are set exactly when the FIFO holds none.
- R3: A header write while the command FIFO is full, a payload write while the write-payload FIFO is full, and a returned word while the read-payload FIFO is full are each dropped and set sticky status bit8. Writing status with bit8 set clears it.
- R4: When the link accepts a header word, `lk_hdr` is 1 and `lk_lp`/`lk_ack` equal option bits 0/1 as they were when that header was written. A header whose data-type low nibble is 9 is a long packet. It is followed by ceil(bytecount/4) payload words with `lk_hdr`=0, in the order they were written and with the same values.
- R5: A header whose data-type low nibble is not 9 is a short packet and takes no payload word: the next word the link accepts is a header.
- R6: Every status flag reflects a push or pop on the next clock cycle, so a status read in the cycle after a write already shows it.
- R7: An accepted header whose data type has low nibble 4, or equals 0x06, is a read request. Status bit6 (read busy) is set from the next cycle until a returned word with `rsp_last`=1 is accepted.
- R8: Returned words are read back from index 2 in arrival order. Status bit5 is set when the read-payload FIFO holds its depth in words, and bit4 is set when it holds none.
- R9: A read of index 2 while the read-payload FIFO is empty returns 0 and sets sticky status bit9. Writing status with bit9 set clears it.
- R10: While `lk_valid` is 1 and `lk_ready` is 0, `lk_valid`, `lk_hdr` and `lk_data` stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write word index |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register read word index |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| lk_valid | output | 1 | Link word valid |
| lk_ready | input | 1 | Link engine accepts the word |
| lk_hdr | output | 1 | Link word is a header |
| lk_data | output | 32 | Link word |
| lk_lp | output | 1 | Packet uses low-power transmission |
| lk_ack | output | 1 | Packet requests an acknowledge |
| rsp_valid | input | 1 | Returned read word valid |
| rsp_data | input | 32 | Returned read word |
| rsp_last | input | 1 | Final word of the response |

## Verification
The bench builds the block with a command depth of 4, a write-payload depth of 8 and a read-payload depth of 4, so every full flag and every overflow case is reached within a few register writes. The small payload depth allows a sweep of long-packet byte counts from 0 through 20, plus a full 32-byte packet. Together these cover every ceil(bytecount/4) boundary and every zero-padded partial word, with byte values and little-endian packing computed in the bench. The same small depths let each stall, drop and empty-read case be provoked directly and checked at the status register.

// File: rtl/dsi_cmd_pkg.sv
// Shared definitions for the command packet front end: register indices,
// status bit positions, the command FIFO entry and data-type decoders.
package dsi_cmd_pkg;
    localparam int DW = 32;
    localparam int REG_AW = 2;

    typedef enum logic [REG_AW-1:0] {
        REG_OPT  = 2'd0,
        REG_HDR  = 2'd1,
        REG_PLD  = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    localparam int ST_CMD_EMPTY = 0;
    localparam int ST_CMD_FULL  = 1;
    localparam int ST_WPL_EMPTY = 2;
    localparam int ST_WPL_FULL  = 3;
    localparam int ST_RPL_EMPTY = 4;
    localparam int ST_RPL_FULL  = 5;
    localparam int ST_RD_BUSY   = 6;
    localparam int ST_OVF       = 8;
    localparam int ST_UDF       = 9;

    typedef struct packed {
        logic          lp;
        logic          ack;
        logic [DW-1:0] hdr;
    } cmd_ent_t;

    // Long packets carry a payload; they are the types with low nibble 9.
    function automatic logic dt_is_long(logic [5:0] dt);
        return dt[3:0] == 4'h9;
    endfunction

    // Read requests: low nibble 4 (generic reads) or the command-set read 0x06.
    function automatic logic dt_is_read(logic [5:0] dt);
        return (dt[3:0] == 4'h4) || (dt == 6'h06);
    endfunction
endpackage

// File: rtl/dsi_sync_fifo.sv
// Synchronous FIFO with a registered occupancy count.
// Assumes: DEPTH >= 2. A push when full and a pop when empty are ignored;
// the caller flags them. The head word is shown combinationally, and the
// empty/full flags come from the count register, so they change one cycle
// after a push or pop.
module dsi_sync_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic do_push, do_pop;

    assign do_push = push && (count != CNT_W'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign head    = mem[rd_ptr];
    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2: occupancy never passes the depth and the flags never conflict.
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (count <= CNT_W'(DEPTH)) && !(empty && full));
    // R6: an accepted push on a non-popping cycle clears empty on the next cycle.
    a_r6_push_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !full) |=> !empty);
endmodule

// File: rtl/dsi_rd_track.sv
// Tracks whether a read request is waiting for its response.
// Assumes: one read is outstanding at a time. If a new read is accepted in the
// same cycle as the final word of the previous response, the new read wins.
module dsi_rd_track
    import dsi_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hdr_accept,
    input  logic [5:0] hdr_dt,
    input  logic       rsp_end,
    output logic       busy
);
    logic start;
    assign start = hdr_accept && dt_is_read(hdr_dt);

    // Busy flag: set by an accepted read header, cleared by the end of the response.
    always_ff @(posedge clk) begin
        if (!rst_n)       busy <= 1'b0;
        else if (start)   busy <= 1'b1;
        else if (rsp_end) busy <= 1'b0;
    end

    // R7: an accepted read request raises busy on the next cycle.
    a_r7_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    // R7: the final response word clears busy unless a new read starts.
    a_r7_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_end && !start) |=> !busy);
endmodule

// File: rtl/dsi_pkt_tx.sv
// Link-side sequencer: presents each queued header, then the payload words
// that its byte count calls for, on a valid/ready word interface.
// Assumes: the payload of a long packet was staged before its header. If the
// payload FIFO runs dry mid-packet, the sequencer waits with lk_valid low.
module dsi_pkt_tx
    import dsi_cmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  cmd_ent_t      cmd_head,
    input  logic          cmd_empty,
    output logic          cmd_pop,
    input  logic [DW-1:0] pld_head,
    input  logic          pld_empty,
    output logic          pld_pop,
    output logic          lk_valid,
    input  logic          lk_ready,
    output logic          lk_hdr,
    output logic [DW-1:0] lk_data,
    output logic          lk_lp,
    output logic          lk_ack
);
    typedef enum logic {S_HDR, S_PLD} tx_state_e;

    tx_state_e   state;
    logic [15:0] rem_q;
    logic        lp_q, ack_q;
    logic [16:0] words_w;
    logic        hdr_long;
    logic        take;

    assign hdr_long = dt_is_long(cmd_head.hdr[5:0]);
    assign words_w  = ({1'b0, cmd_head.hdr[23:8]} + 17'd3) >> 2;
    assign lk_hdr   = (state == S_HDR);
    assign lk_valid = lk_hdr ? !cmd_empty : !pld_empty;
    assign lk_data  = lk_hdr ? cmd_head.hdr : pld_head;
    assign lk_lp    = lk_hdr ? cmd_head.lp  : lp_q;
    assign lk_ack   = lk_hdr ? cmd_head.ack : ack_q;
    assign take     = lk_valid && lk_ready;
    assign cmd_pop  = take && lk_hdr;
    assign pld_pop  = take && !lk_hdr;

    // Packet sequencing: load the word count at the header, count it down in payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_HDR;
            rem_q <= '0;
            lp_q  <= 1'b0;
            ack_q <= 1'b0;
        end else if (cmd_pop) begin
            lp_q  <= cmd_head.lp;
            ack_q <= cmd_head.ack;
            rem_q <= words_w[15:0];
            state <= (hdr_long && words_w != '0) ? S_PLD : S_HDR;
        end else if (pld_pop) begin
            rem_q <= rem_q - 1'b1;
            if (rem_q == 16'd1) state <= S_HDR;
        end
    end

    // R10: a stalled word is held unchanged.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_ready) |=> (lk_valid && $stable(lk_data) && $stable(lk_hdr)));
    // R5: after a short header is taken, the next word offered is a header.
    a_r5_short_no_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (take && lk_hdr && !dt_is_long(lk_data[5:0])) |=> lk_hdr);
    // R4: the low-power and acknowledge options stay fixed through a payload word stream.
    a_r4_opts_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pld_pop && rem_q != 16'd1) |=> ($stable(lk_lp) && $stable(lk_ack)));
endmodule

// File: rtl/dsi_cmd_pkt_if.sv
// Register front end for queuing command packets and collecting read data.
// Assumes: one register access per cycle per port. Read data is registered
// and valid in the cycle after rd_en. Writes to the header index commit the
// packet staged so far. Dropped writes and empty reads are recorded in sticky
// status bits that are cleared by writing 1 to them.
module dsi_cmd_pkt_if
    import dsi_cmd_pkg::*;
#(
    parameter int CMD_DEPTH = 4,
    parameter int PLD_DEPTH = 16,
    parameter int RSP_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic              lk_valid,
    input  logic              lk_ready,
    output logic              lk_hdr,
    output logic [DW-1:0]     lk_data,
    output logic              lk_lp,
    output logic              lk_ack,
    input  logic              rsp_valid,
    input  logic [DW-1:0]     rsp_data,
    input  logic              rsp_last
);
    localparam int CMD_W = $bits(cmd_ent_t);

    logic [1:0]    opt_q;
    logic          ovf_q, udf_q;
    logic          cmd_empty, cmd_full, cmd_pop;
    logic          wpl_empty, wpl_full, wpl_pop;
    logic          rpl_empty, rpl_full;
    logic          rd_busy;
    logic [CMD_W-1:0] cmd_head_raw;
    cmd_ent_t      cmd_head, cmd_in;
    logic [DW-1:0] wpl_head, rpl_head;
    logic          hdr_wr, pld_wr, stat_wr, pld_rd;
    logic          cmd_push, wpl_push, rpl_push, rpl_pop;
    logic          ovf_set, udf_set;
    logic [DW-1:0] status_w;

    assign hdr_wr   = wr_en && (wr_addr == REG_HDR);
    assign pld_wr   = wr_en && (wr_addr == REG_PLD);
    assign stat_wr  = wr_en && (wr_addr == REG_STAT);
    assign pld_rd   = rd_en && (rd_addr == REG_PLD);
    assign cmd_push = hdr_wr && !cmd_full;
    assign wpl_push = pld_wr && !wpl_full;
    assign rpl_push = rsp_valid && !rpl_full;
    assign rpl_pop  = pld_rd && !rpl_empty;
    assign ovf_set  = (hdr_wr && cmd_full) || (pld_wr && wpl_full) || (rsp_valid && rpl_full);
    assign udf_set  = pld_rd && rpl_empty;

    assign cmd_in.lp  = opt_q[0];
    assign cmd_in.ack = opt_q[1];
    assign cmd_in.hdr = wr_data;
    assign cmd_head   = cmd_ent_t'(cmd_head_raw);

    // The three queues share one FIFO design; widths and depths differ.
    dsi_sync_fifo #(.WIDTH(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
        .clk(clk), .rst_n(rst_n), .push(cmd_push), .din(cmd_in), .pop(cmd_pop),
        .head(cmd_head_raw), .empty(cmd_empty), .full(cmd_full));

    dsi_sync_fifo #(.WIDTH(DW), .DEPTH(PLD_DEPTH)) u_wpl_fifo (
        .clk(clk), .rst_n(rst_n), .push(wpl_push), .din(wr_data), .pop(wpl_pop),
        .head(wpl_head), .empty(wpl_empty), .full(wpl_full));

    dsi_sync_fifo #(.WIDTH(DW), .DEPTH(RSP_DEPTH)) u_rpl_fifo (
        .clk(clk), .rst_n(rst_n), .push(rpl_push), .din(rsp_data), .pop(rpl_pop),
        .head(rpl_head), .empty(rpl_empty), .full(rpl_full));

    dsi_pkt_tx u_tx (
        .clk(clk), .rst_n(rst_n),
        .cmd_head(cmd_head), .cmd_empty(cmd_empty), .cmd_pop(cmd_pop),
        .pld_head(wpl_head), .pld_empty(wpl_empty), .pld_pop(wpl_pop),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_hdr(lk_hdr),
        .lk_data(lk_data), .lk_lp(lk_lp), .lk_ack(lk_ack));

    dsi_rd_track u_rd_track (
        .clk(clk), .rst_n(rst_n),
        .hdr_accept(cmd_push), .hdr_dt(wr_data[5:0]),
        .rsp_end(rsp_valid && rsp_last && !rpl_full),
        .busy(rd_busy));

    // Status word assembled from registered flags.
    always_comb begin
        status_w = '0;
        status_w[ST_CMD_EMPTY] = cmd_empty;
        status_w[ST_CMD_FULL]  = cmd_full;
        status_w[ST_WPL_EMPTY] = wpl_empty;
        status_w[ST_WPL_FULL]  = wpl_full;
        status_w[ST_RPL_EMPTY] = rpl_empty;
        status_w[ST_RPL_FULL]  = rpl_full;
        status_w[ST_RD_BUSY]   = rd_busy;
        status_w[ST_OVF]       = ovf_q;
        status_w[ST_UDF]       = udf_q;
    end

    // Option register write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 opt_q <= '0;
        else if (wr_en && (wr_addr == REG_OPT))     opt_q <= wr_data[1:0];
    end

    // Sticky error bits: a new event takes priority over a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            udf_q <= 1'b0;
        end else begin
            if (ovf_set)                        ovf_q <= 1'b1;
            else if (stat_wr && wr_data[ST_OVF]) ovf_q <= 1'b0;
            if (udf_set)                        udf_q <= 1'b1;
            else if (stat_wr && wr_data[ST_UDF]) udf_q <= 1'b0;
        end
    end

    // Registered read data mux.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            case (rd_addr)
                REG_OPT:  rd_data <= {{(DW-2){1'b0}}, opt_q};
                REG_PLD:  rd_data <= rpl_empty ? '0 : rpl_head;
                REG_STAT: rd_data <= status_w;
                default:  rd_data <= '0;
            endcase
        end
    end

    // R3: the overflow flag holds until a write-one clear.
    a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(stat_wr && wr_data[ST_OVF])) |=> ovf_q);
    // R3: a header write into a full command FIFO flags overflow.
    a_r3_hdr_drop_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_wr && cmd_full) |=> ovf_q);
    // R9: a payload read of an empty FIFO returns zero and flags underflow.
    a_r9_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (pld_rd && rpl_empty) |=> (rd_data == '0 && udf_q));
    // R9: the underflow flag holds until a write-one clear.
    a_r9_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (udf_q && !(stat_wr && wr_data[ST_UDF])) |=> udf_q);
endmodule

// File: tb/tb_dsi_cmd_pkt_if.sv
// Bench: models the link engine, sweeps long-packet sizes and provokes every
// full, drop and empty-read case on a small configuration.
module tb_dsi_cmd_pkt_if;
    localparam int CLK_PERIOD = 10;
    localparam int CMD_D = 4;
    localparam int PLD_D = 8;
    localparam int RSP_D = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        lk_valid, lk_hdr, lk_lp, lk_ack;
    logic        lk_ready = 1'b0;
    logic [31:0] lk_data;
    logic        rsp_valid = 1'b0, rsp_last = 1'b0;
    logic [31:0] rsp_data = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0] rec_data [256];
    logic        rec_hdr  [256];
    logic        rec_lp   [256];
    logic        rec_ack  [256];
    int          rec_n = 0;

    dsi_cmd_pkt_if #(.CMD_DEPTH(CMD_D), .PLD_DEPTH(PLD_D), .RSP_DEPTH(RSP_D)) dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_hdr(lk_hdr),
        .lk_data(lk_data), .lk_lp(lk_lp), .lk_ack(lk_ack),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Link engine model: record every word taken at the coming edge.
    always @(negedge clk) begin
        #1;
        if (lk_valid && lk_ready && rec_n < 256) begin
            rec_data[rec_n] = lk_data;
            rec_hdr[rec_n]  = lk_hdr;
            rec_lp[rec_n]   = lk_lp;
            rec_ack[rec_n]  = lk_ack;
            rec_n = rec_n + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rsp_word(input logic [31:0] d, input logic last);
        rsp_valid = 1'b1; rsp_data = d; rsp_last = last;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_last = 1'b0;
    endtask

    function automatic logic [7:0] pbyte(input int wc, input int i);
        return 8'((wc * 7 + i * 13 + 1) & 255);
    endfunction

    function automatic logic [31:0] pword(input int wc, input int w);
        logic [31:0] v = '0;
        for (int b = 0; b < 4; b++)
            if (w * 4 + b < wc) v[8*b +: 8] = pbyte(wc, w * 4 + b);
        return v;
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] v, held;
        int base, nw;
        logic lp, ack;

        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        bus_rd(2'd3, v); check("R1 status", v, 32'h15);
        bus_rd(2'd0, v); check("R1 options", v, 32'h0);

        // R2/R6: fill the command FIFO with the link stalled
        lk_ready = 1'b0;
        for (int k = 0; k < CMD_D; k++) begin
            bus_wr(2'd1, {8'h0, 8'h00, 8'(k), 8'h05});
            bus_rd(2'd3, v);
            check("R6 R2 cmd fill status", v, (k == CMD_D - 1) ? 32'h16 : 32'h14);
        end

        // R3: header into a full FIFO is dropped and flagged; clear by writing 1
        bus_wr(2'd1, 32'h0000_FF05);
        bus_rd(2'd3, v); check("R3 hdr overflow", v, 32'h116);
        bus_wr(2'd3, 32'h100);
        bus_rd(2'd3, v); check("R3 ovf clear", v, 32'h16);

        // R10: stalled word held
        held = lk_data;
        idle(3);
        check("R10 valid held", {31'b0, lk_valid}, 32'h1);
        check("R10 data held", lk_data, held);

        // R5: short headers drain with no payload
        base = rec_n;
        lk_ready = 1'b1;
        idle(20);
        check("R5 short count", 32'(rec_n - base), 32'(CMD_D));
        for (int k = 0; k < CMD_D; k++) begin
            check("R5 short hdr flag", {31'b0, rec_hdr[base + k]}, 32'h1);
            check("R5 short hdr data", rec_data[base + k], {16'h0, 8'(k), 8'h05});
        end

        // R4: long packet sweep over byte counts 0..20 with option bits varied
        for (int wc = 0; wc <= 20; wc++) begin
            lp = 1'(wc % 2);
            ack = 1'(wc / 2 % 2);
            nw = (wc + 3) / 4;
            bus_wr(2'd0, {30'b0, ack, lp});
            for (int w = 0; w < nw; w++) bus_wr(2'd2, pword(wc, w));
            base = rec_n;
            bus_wr(2'd1, {8'h0, 16'(wc), 2'(wc % 4), 6'h29});
            idle(nw + 6);
            check("R4 word count", 32'(rec_n - base), 32'(nw + 1));
            check("R4 header word", rec_data[base], {8'h0, 16'(wc), 2'(wc % 4), 6'h29});
            check("R4 header flag/lp/ack", {29'b0, rec_hdr[base], rec_lp[base], rec_ack[base]},
                  {29'b0, 1'b1, lp, ack});
            for (int w = 0; w < nw; w++) begin
                check("R4 payload word", rec_data[base + 1 + w], pword(wc, w));
                check("R4 payload flag", {31'b0, rec_hdr[base + 1 + w]}, 32'h0);
            end
        end
        bus_wr(2'd0, 32'h0);

        // R2/R3: fill the write-payload FIFO, overflow it, then send it
        for (int w = 0; w < PLD_D; w++) bus_wr(2'd2, pword(32, w));
        bus_rd(2'd3, v); check("R2 wpl full status", v, 32'h19);
        bus_wr(2'd2, 32'hDEAD_BEEF);
        bus_rd(2'd3, v); check("R3 wpl overflow", v, 32'h119);
        bus_wr(2'd3, 32'h100);
        base = rec_n;
        bus_wr(2'd1, {8'h0, 16'd32, 8'h39});
        idle(PLD_D + 6);
        check("R4 full packet count", 32'(rec_n - base), 32'(PLD_D + 1));
        for (int w = 0; w < PLD_D; w++)
            check("R4 full packet word", rec_data[base + 1 + w], pword(32, w));
        bus_rd(2'd3, v); check("R3 after drain", v, 32'h15);

        // R7: read request raises busy until the last response word
        bus_wr(2'd1, 32'h0000_0114);
        bus_rd(2'd3, v); check("R7 busy set", v & 32'h40, 32'h40);
        idle(4);
        bus_rd(2'd3, v); check("R7 busy held", v, 32'h55);
        rsp_word(32'h1111_0001, 1'b0);
        rsp_word(32'h2222_0002, 1'b0);
        bus_rd(2'd3, v); check("R7 busy mid response", v, 32'h45);
        rsp_word(32'h3333_0003, 1'b1);
        bus_rd(2'd3, v); check("R7 busy cleared", v, 32'h05);

        // R8: drain in order
        bus_rd(2'd2, v); check("R8 word 0", v, 32'h1111_0001);
        bus_rd(2'd2, v); check("R8 word 1", v, 32'h2222_0002);
        bus_rd(2'd2, v); check("R8 word 2", v, 32'h3333_0003);

        // R9: empty read returns zero and flags underflow
        bus_rd(2'd2, v); check("R9 empty read", v, 32'h0);
        bus_rd(2'd3, v); check("R9 udf flag", v, 32'h215);
        bus_wr(2'd3, 32'h200);
        bus_rd(2'd3, v); check("R9 udf clear", v, 32'h15);

        // R8/R3: fill the read FIFO, overflow it, drain
        for (int k = 0; k < RSP_D; k++) rsp_word(32'hA000_0000 + 32'(k), 1'b0);
        bus_rd(2'd3, v); check("R8 rpl full", v, 32'h25);
        rsp_word(32'hBAD0_0000, 1'b0);
        bus_rd(2'd3, v); check("R3 rsp overflow", v, 32'h125);
        for (int k = 0; k < RSP_D; k++) begin
            bus_rd(2'd2, v); check("R8 fill drain", v, 32'hA000_0000 + 32'(k));
        end
        bus_wr(2'd3, 32'h100);
        bus_rd(2'd3, v); check("R8 empty again", v, 32'h15);

        // R7: the command-set read type 0x06 also raises busy
        bus_wr(2'd1, 32'h0000_0A06);
        idle(4);
        bus_rd(2'd3, v); check("R7 dcs read busy", v, 32'h55);
        rsp_word(32'h0000_00C3, 1'b1);
        bus_rd(2'd3, v); check("R7 dcs busy cleared", v, 32'h05);
        bus_rd(2'd2, v); check("R8 dcs response", v, 32'h0000_00C3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule